// File: doc/BRIEF.md
# Leveled Interrupt Pending Resolver

This block gathers up to 32 interrupt request lines into a pending register and qualifies that register with a software-written enable register. The lines are sorted into numbered priority levels (1 to at most 7) through per-level membership masks given as parameters. On every cycle the block searches for the highest level that has at least one enabled pending line and that lies strictly above the processor's current interrupt level. It reports that level, or 0 when there is none, and drives a request output whenever the reported level is nonzero.

Line events arrive as an index with an assert/deassert flag. The event is dropped when the index is at or beyond the configured interrupt count. The edge/level type of each line is a parameter. Deasserting a level-type line clears its pending bit. Edge-type bits stay set until software clears them with a write-one-to-clear mask, and that mask does not touch level-type bits. Each compare-timer match input sets the line mapped to that timer.

A two-state machine holds the request. It is in `RS_IDLE` (request low) or `RS_REQ` (request high). The transition RAISE goes from `RS_IDLE` to `RS_REQ` when some level qualifies. The transition DROP goes from `RS_REQ` to `RS_IDLE` when no level qualifies. HOLD keeps the current state in every other case. The level and the request are registered, so each is one cycle behind the pending, enable and current-level values that produced it.

Top module: `irq_level_resolver`

## Requirements
- R1: While reset is active, the pending set, the enable register, the reported level and the request output are all 0.
- R2: Only lines set in both the pending set and the enable register count (effective set = pending AND enable). A pending line that is disabled never yields a nonzero level.
- R3: The reported level is the highest level L (1..NUM_LEVELS) whose mask overlaps the effective set and for which L > current level. Levels at or below the current level are never reported.
- R4: When no level qualifies, the reported level is 0 and the request is low. The request is high exactly when the reported level is nonzero.
- R5: An in-range event with the active flag set sets that line's pending bit, which is visible on the pending output after the next clock edge.
- R6: An in-range event with the active flag clear clears the bit of a level-type line. An edge-type line's bit is unchanged.
- R7: An event whose index is at or beyond NUM_IRQ changes nothing, and pending bits at or beyond NUM_IRQ always read 0.
- R8: A match on timer k sets the pending bit of the line TIMER_LINE[k].
- R9: A software clear write clears the edge-type pending bits where the mask holds 1 and leaves level-type bits unchanged. A set arriving in the same cycle wins over the clear.
- R10: The level and request outputs are registered. They reflect the pending set, the enable register and the current level as they stood just before the clock edge.
- R11: An enable write replaces the enable register. The new value shows on the enable output after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_valid_i | input | 1 | Line event strobe |
| irq_idx_i | input | IDX_W | Line index of the event |
| irq_active_i | input | 1 | 1: line asserted, 0: line deasserted |
| tmr_match_i | input | NUM_TIMERS | Per-timer compare match pulses |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NUM_LINES | Enable register write value |
| clr_we_i | input | 1 | Software clear strobe |
| clr_mask_i | input | NUM_LINES | Write-one-to-clear mask for edge lines |
| cur_level_i | input | 3 | Processor's current interrupt level |
| pending_o | output | NUM_LINES | Pending set |
| enable_o | output | NUM_LINES | Enable register |
| pend_level_o | output | 3 | Highest qualifying level, 0 if none |
| irq_req_o | output | 1 | Interrupt request |

## Verification
The bench first targets the threshold boundary. A line at level 3 has to disappear when the current level equals 3, so a design that compared with >= instead of > would keep requesting. It then sets a disabled pending line, which catches a design that ignores the enable register. Deasserting edge and level lines side by side, sending out-of-range indices and clearing with an all-ones mask would expose type confusion: edge bits lost on deassert, level bits lost on clear, or a stray bit above the interrupt count. A set and a clear on the same line in one cycle checks which one wins. A long random run compares every cycle against a model one edge behind, which catches an output that is combinational or two cycles late.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    // Widest level number the resolver can report
    localparam int MAX_LEVELS = 7;
    localparam int LVL_W      = 3;

    typedef enum logic [0:0] {
        RS_IDLE = 1'b0,
        RS_REQ  = 1'b1
    } rs_state_e;

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_res_pkg::*;
#(
    parameter int                              NUM_LINES  = 32,
    parameter int                              NUM_IRQ    = 24,
    parameter int                              NUM_TIMERS = 2,
    parameter logic [NUM_LINES-1:0]            EDGE_MASK  = '0,
    parameter logic [NUM_TIMERS-1:0][7:0]      TIMER_LINE = '0,
    localparam int                             IDX_W      = $clog2(NUM_LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_valid,
    input  logic [IDX_W-1:0]      ev_idx,
    input  logic                  ev_active,
    input  logic [NUM_TIMERS-1:0] tmr_hit,
    input  logic                  clr_we,
    input  logic [NUM_LINES-1:0]  clr_mask,
    output logic [NUM_LINES-1:0]  pend_q
);

    localparam logic [IDX_W:0] IDX_LIMIT = (IDX_W+1)'(NUM_IRQ);

    logic                 idx_ok;
    logic [NUM_LINES-1:0] pend_d;

    assign idx_ok = ({1'b0, ev_idx} < IDX_LIMIT);

    always_comb begin
        pend_d = pend_q;
        // software clear only reaches edge-type lines
        if (clr_we) begin
            pend_d = pend_d & ~(clr_mask & EDGE_MASK);
        end
        // deassert drops level-type lines only
        if (ev_valid && idx_ok && !ev_active && !EDGE_MASK[ev_idx]) begin
            pend_d[ev_idx] = 1'b0;
        end
        // sets are applied last so they win over any clear
        if (ev_valid && idx_ok && ev_active) begin
            pend_d[ev_idx] = 1'b1;
        end
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (tmr_hit[t]) begin
                pend_d[TIMER_LINE[t][IDX_W-1:0]] = 1'b1;
            end
        end
        // lines beyond the configured count never hold state
        for (int i = 0; i < NUM_LINES; i++) begin
            if (i >= NUM_IRQ) begin
                pend_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan
    import irq_res_pkg::*;
#(
    parameter int                                   NUM_LINES  = 32,
    parameter int                                   NUM_LEVELS = 5,
    parameter logic [MAX_LEVELS:0][NUM_LINES-1:0]   LEVEL_MASK = '0
) (
    input  logic [NUM_LINES-1:0] eff_set,
    input  logic [LVL_W-1:0]     cur_level,
    output logic                 any_hit,
    output logic [LVL_W-1:0]     best_level
);

    logic [NUM_LEVELS:0] lvl_hit;

    assign lvl_hit[0] = 1'b0;

    // one qualifier per configured level
    for (genvar L = 1; L <= NUM_LEVELS; L++) begin : g_lvl
        assign lvl_hit[L] = (|(LEVEL_MASK[L] & eff_set)) &&
                            (LVL_W'(L) > cur_level);
    end

    // later (higher) levels overwrite, so the top hit wins
    always_comb begin
        best_level = '0;
        for (int l = 1; l <= NUM_LEVELS; l++) begin
            if (lvl_hit[l]) begin
                best_level = LVL_W'(l);
            end
        end
    end

    assign any_hit = |lvl_hit;

endmodule

// File: rtl/irq_res_fsm.sv
module irq_res_fsm
    import irq_res_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_hit,
    input  logic [LVL_W-1:0] best_level,
    output logic [LVL_W-1:0] level_q,
    output logic             req_o
);

    rs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (any_hit)  state_d = RS_REQ;   // RAISE
            RS_REQ:  if (!any_hit) state_d = RS_IDLE;  // DROP
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            level_q <= '0;
        end else begin
            state_q <= state_d;
            level_q <= any_hit ? best_level : '0;
        end
    end

    always_comb begin
        req_o = (state_q == RS_REQ);
    end

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
    import irq_res_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int NUM_IRQ    = 24,
    parameter int NUM_LEVELS = 5,
    parameter int NUM_TIMERS = 2,
    // index 0 unused; index L holds the lines of level L
    parameter logic [MAX_LEVELS:0][NUM_LINES-1:0] LEVEL_MASK = {
        32'h0000_0000, 32'h0000_0000, 32'h000F_0000, 32'h00F0_0000,
        32'h0000_F000, 32'h0000_0F00, 32'h0000_00FF, 32'h0000_0000},
    // 1 = edge-type line, 0 = level-type line; timer lines are edge-type
    parameter logic [NUM_LINES-1:0]         EDGE_MASK  = 32'h00E5_5A7C,
    parameter logic [NUM_TIMERS-1:0][7:0]   TIMER_LINE = {8'd22, 8'd6},
    localparam int                          IDX_W      = $clog2(NUM_LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  irq_valid_i,
    input  logic [IDX_W-1:0]      irq_idx_i,
    input  logic                  irq_active_i,
    input  logic [NUM_TIMERS-1:0] tmr_match_i,
    input  logic                  en_we_i,
    input  logic [NUM_LINES-1:0]  en_wdata_i,
    input  logic                  clr_we_i,
    input  logic [NUM_LINES-1:0]  clr_mask_i,
    input  logic [LVL_W-1:0]      cur_level_i,
    output logic [NUM_LINES-1:0]  pending_o,
    output logic [NUM_LINES-1:0]  enable_o,
    output logic [LVL_W-1:0]      pend_level_o,
    output logic                  irq_req_o
);

    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] eff_set;
    logic                 any_hit;
    logic [LVL_W-1:0]     best_level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we_i) begin
            en_q <= en_wdata_i;
        end
    end

    irq_pend_reg #(
        .NUM_LINES (NUM_LINES),
        .NUM_IRQ   (NUM_IRQ),
        .NUM_TIMERS(NUM_TIMERS),
        .EDGE_MASK (EDGE_MASK),
        .TIMER_LINE(TIMER_LINE)
    ) i_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (irq_valid_i),
        .ev_idx   (irq_idx_i),
        .ev_active(irq_active_i),
        .tmr_hit  (tmr_match_i),
        .clr_we   (clr_we_i),
        .clr_mask (clr_mask_i),
        .pend_q   (pend_q)
    );

    assign eff_set = pend_q & en_q;

    irq_level_scan #(
        .NUM_LINES (NUM_LINES),
        .NUM_LEVELS(NUM_LEVELS),
        .LEVEL_MASK(LEVEL_MASK)
    ) i_scan (
        .eff_set   (eff_set),
        .cur_level (cur_level_i),
        .any_hit   (any_hit),
        .best_level(best_level)
    );

    irq_res_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_hit   (any_hit),
        .best_level(best_level),
        .level_q   (pend_level_o),
        .req_o     (irq_req_o)
    );

    assign pending_o = pend_q;
    assign enable_o  = en_q;

endmodule

// File: rtl/irq_res_chk.sv
module irq_res_chk
    import irq_res_pkg::*;
#(
    parameter int                         NUM_LINES  = 32,
    parameter int                         NUM_IRQ    = 24,
    parameter int                         NUM_TIMERS = 2,
    parameter logic [NUM_LINES-1:0]       EDGE_MASK  = '0,
    parameter logic [NUM_TIMERS-1:0][7:0] TIMER_LINE = '0,
    localparam int                        IDX_W      = $clog2(NUM_LINES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  irq_valid_i,
    input logic [IDX_W-1:0]      irq_idx_i,
    input logic                  irq_active_i,
    input logic [NUM_TIMERS-1:0] tmr_match_i,
    input logic                  clr_we_i,
    input logic [NUM_LINES-1:0]  clr_mask_i,
    input logic [LVL_W-1:0]      cur_level_i,
    input logic [NUM_LINES-1:0]  pending_o,
    input logic [NUM_LINES-1:0]  enable_o,
    input logic [LVL_W-1:0]      pend_level_o,
    input logic                  irq_req_o
);

    function automatic logic [NUM_LINES-1:0] over_mask();
        logic [NUM_LINES-1:0] m;
        for (int i = 0; i < NUM_LINES; i++) m[i] = (i >= NUM_IRQ);
        return m;
    endfunction

    localparam logic [NUM_LINES-1:0] OVER = over_mask();

    // R1
    rst_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (pending_o == '0 && enable_o == '0 &&
                    pend_level_o == '0 && !irq_req_o));

    // R2
    masked_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_level_o != '0) |-> (|($past(pending_o) & $past(enable_o))));

    // R3
    above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (pend_level_o > $past(cur_level_i)));

    // R4
    req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o == (pend_level_o != '0));

    // R5
    line_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_i && irq_active_i && (32'(irq_idx_i) < NUM_IRQ))
        |=> pending_o[$past(irq_idx_i)]);

    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pending_o) & EDGE_MASK) & ~pending_o &
                   ~($past(clr_we_i) ? $past(clr_mask_i) : '0)) == '0));

    // R7
    no_stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o & OVER) == '0);

    // R9
    level_clr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_valid_i && tmr_match_i == '0) |=> $stable(pending_o & ~EDGE_MASK));

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        // R8
        timer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_match_i[t] |=> pending_o[TIMER_LINE[t][IDX_W-1:0]]);
    end

endmodule

bind irq_level_resolver irq_res_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_IRQ   (NUM_IRQ),
    .NUM_TIMERS(NUM_TIMERS),
    .EDGE_MASK (EDGE_MASK),
    .TIMER_LINE(TIMER_LINE)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_valid_i (irq_valid_i),
    .irq_idx_i   (irq_idx_i),
    .irq_active_i(irq_active_i),
    .tmr_match_i (tmr_match_i),
    .clr_we_i    (clr_we_i),
    .clr_mask_i  (clr_mask_i),
    .cur_level_i (cur_level_i),
    .pending_o   (pending_o),
    .enable_o    (enable_o),
    .pend_level_o(pend_level_o),
    .irq_req_o   (irq_req_o)
);

// File: tb/test_irq_level_resolver.sv
module test_irq_level_resolver;

    localparam int N_IRQ = 24;
    localparam logic [31:0] EDGE = 32'h00E5_5A7C;
    localparam logic [7:0][31:0] LMASK = {
        32'h0000_0000, 32'h0000_0000, 32'h000F_0000, 32'h00F0_0000,
        32'h0000_F000, 32'h0000_0F00, 32'h0000_00FF, 32'h0000_0000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_valid_i = 1'b0;
    logic [4:0]  irq_idx_i = '0;
    logic        irq_active_i = 1'b0;
    logic [1:0]  tmr_match_i = '0;
    logic        en_we_i = 1'b0;
    logic [31:0] en_wdata_i = '0;
    logic        clr_we_i = 1'b0;
    logic [31:0] clr_mask_i = '0;
    logic [2:0]  cur_level_i = '0;
    logic [31:0] pending_o, enable_o;
    logic [2:0]  pend_level_o;
    logic        irq_req_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_pend = '0;
    logic [31:0] m_en   = '0;
    logic [2:0]  m_lvl  = '0;

    always #2.5 clk = ~clk;

    irq_level_resolver i_irq_level_resolver (.*);

    function automatic logic [2:0] f_level(logic [31:0] p, logic [31:0] e, logic [2:0] cur);
        logic [2:0] r = '0;
        for (int l = 5; l >= 1; l--) begin
            if (l > cur && (LMASK[l] & p & e) != 0) begin
                r = 3'(l);
                break;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] f_next(logic [31:0] p);
        logic [31:0] n = p;
        if (clr_we_i) n &= ~(clr_mask_i & EDGE);
        if (irq_valid_i && irq_idx_i < N_IRQ) begin
            if (irq_active_i) n[irq_idx_i] = 1'b1;
            else if (!EDGE[irq_idx_i]) n[irq_idx_i] = 1'b0;
        end
        if (tmr_match_i[0]) n[6] = 1'b1;
        if (tmr_match_i[1]) n[22] = 1'b1;
        return n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        irq_valid_i = 1'b0; irq_active_i = 1'b0; tmr_match_i = '0;
        en_we_i = 1'b0; clr_we_i = 1'b0; clr_mask_i = '0;
    endtask

    // one clock: update model at the edge, compare at the falling edge
    task automatic cyc();
        @(posedge clk);
        m_lvl  = f_level(m_pend, m_en, cur_level_i);   // R10: pre-edge values
        m_pend = f_next(m_pend);
        if (en_we_i) m_en = en_wdata_i;
        @(negedge clk);
        chk("R5 pending", pending_o, m_pend);
        chk("R11 enable", enable_o, m_en);
        chk("R3 level", 32'(pend_level_o), 32'(m_lvl));
        chk("R4 request", 32'(irq_req_o), 32'(m_lvl != 0));
        idle();
    endtask

    task automatic ev(input int idx, input logic act);
        irq_valid_i = 1'b1; irq_idx_i = 5'(idx); irq_active_i = act;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 pending", pending_o, 0);
        chk("R1 enable", enable_o, 0);
        chk("R1 level", 32'(pend_level_o), 0);
        chk("R1 request", 32'(irq_req_o), 0);
        rst_n = 1'b1;

        // R2: pending but disabled
        ev(0, 1'b1); cyc();
        chk("R2 disabled", 32'(pend_level_o), 0);
        en_we_i = 1'b1; en_wdata_i = '1; cyc(); cyc();
        chk("R2 enabled", 32'(pend_level_o), 1);
        // R3: level 3 beats level 1, threshold is strict
        ev(12, 1'b1); cyc();
        chk("R3 highest", 32'(pend_level_o), 3);
        cur_level_i = 3'd2; cyc(); cyc();
        chk("R3 below", 32'(pend_level_o), 3);
        cur_level_i = 3'd3; cyc(); cyc();
        chk("R3 equal", 32'(pend_level_o), 0);
        chk("R4 none", 32'(irq_req_o), 0);
        cur_level_i = 3'd0;
        // R6: edge keeps, level drops
        ev(12, 1'b0);
        chk("R6 edge kept", 32'(pending_o[12]), 1);
        ev(0, 1'b0);
        chk("R6 level cleared", 32'(pending_o[0]), 0);
        // R7: out-of-range index
        ev(26, 1'b1);
        chk("R7 ignored", pending_o, 32'h0000_1000);
        // R8: timer 0 -> line 6
        tmr_match_i = 2'b01; cyc();
        chk("R8 timer", pending_o, 32'h0000_1040);
        // R9: clear hits edge lines only; set wins
        ev(1, 1'b1);
        clr_we_i = 1'b1; clr_mask_i = '1; cyc();
        chk("R9 clear", pending_o, 32'h0000_0002);
        clr_we_i = 1'b1; clr_mask_i = 32'h4;
        irq_valid_i = 1'b1; irq_idx_i = 5'd2; irq_active_i = 1'b1; cyc();
        chk("R9 set wins", pending_o, 32'h0000_0006);

        // random mix, R10 checked every cycle by the model
        for (int n = 0; n < 3000; n++) begin
            irq_valid_i  = ($urandom % 2) == 0;
            irq_idx_i    = 5'($urandom % 28);
            irq_active_i = ($urandom % 5) < 3;
            tmr_match_i  = 2'(($urandom % 10) == 0 ? $urandom : 0);
            en_we_i      = ($urandom % 20) == 0;
            en_wdata_i   = $urandom;
            clr_we_i     = ($urandom % 10) == 0;
            clr_mask_i   = $urandom;
            cur_level_i  = 3'($urandom % 8);
            cyc();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule